// File: doc/BRIEF.md
# Shared-Bus Register Datapath

This block is a small register-transfer datapath. Four general registers, an address register and a data register sit around one shared bus. An external data word can also drive that bus. A binary source code picks the single word that drives the bus. A destination code is decoded into one-hot load enables. When the transfer guard is high, the selected destination captures the bus value on the rising clock edge.

A small word memory sits beside the registers. A read copies the word at the address register into the data register. A write stores a chosen general register at that address. A separate swap path lets two general registers exchange their contents on a single edge without losing either value. Control logic around the block sequences these operations one cycle at a time.

Top module: `rbd_datapath`

## Requirements
- R1: Asserting `rst_n` low clears all general registers, the address register and the data register to zero at once, without waiting for a clock edge. The memory contents are not cleared.
- R2: `bus_o` shows the source chosen by `bus_src`. Codes 0 to 3 select general register 0 to 3, code 4 the address register, code 5 the data register and code 6 `ext_din`. Code 7 drives zero.
- R3: When `xfer_en` is 1 and `swap_en` is 0, the destination named by `bus_dst` takes the bus value on the next rising edge. Codes 0 to 3 name the general registers, 4 the address register and 5 the data register. Codes 6 and 7 name no register, so nothing changes.
- R4: When `xfer_en` is 0, no bus transfer takes place and every destination holds its value.
- R5: When `swap_en` is 1, general registers `swap_a` and `swap_b` exchange values on one edge. Any bus transfer requested in that cycle is suppressed. If `swap_a` equals `swap_b`, the register is unchanged.
- R6: When `mem_rd` is 1 and `mem_wr` is 0, the data register loads the memory word at the address given by the low address bits of the address register. This read takes priority over a bus load into the data register in the same cycle.
- R7: When `mem_wr` is 1, general register `wr_src` is stored at the memory word given by the low bits of the address register. A later read returns that value.
- R8: When `mem_rd` and `mem_wr` are both 1, only the write happens. The data register holds its value unless a bus transfer targets it.
- R9: A single bus transfer loads at most one register. All registers other than the destination keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| ext_din | input | DATA_W | External word that can drive the bus (source code 6) |
| bus_src | input | 3 | Bus source code |
| bus_dst | input | 3 | Bus destination code |
| xfer_en | input | 1 | Guard for the bus transfer |
| swap_en | input | 1 | Exchange two general registers |
| swap_a | input | 2 | First register of the swap |
| swap_b | input | 2 | Second register of the swap |
| mem_rd | input | 1 | Memory read into the data register |
| mem_wr | input | 1 | Memory write from a general register |
| wr_src | input | 2 | General register written to memory |
| bus_o | output | DATA_W | Current bus value |
| gpr_o | output | 4*DATA_W | General registers, register i at bits [i*DATA_W +: DATA_W] |
| ar_o | output | DATA_W | Address register |
| dr_o | output | DATA_W | Data register |

## Verification
All registers are visible at the ports. A wrong load decode or a lost swap value therefore shows up on `gpr_o`, `ar_o` or `dr_o` at the first falling edge after the faulty clock edge. A memory fault stays hidden until a later read moves the stored word into `dr_o`. For that reason, each write is followed by reads from two different addresses, so that an aliased address or the wrong write source becomes visible within two cycles. Read/write priority faults appear as a change on `dr_o` in a cycle where it should have held its value.

// File: rtl/rbd_pkg.sv
package rbd_pkg;
  // Bus slots that follow the general registers, in code order.
  localparam int unsigned OFS_AR   = 0;
  localparam int unsigned OFS_DR   = 1;
  localparam int unsigned OFS_EXT  = 2;
  localparam int unsigned EXTRA_SRC = 3;
  // Destinations that follow the general registers.
  localparam int unsigned EXTRA_DST = 2;
endpackage

// File: rtl/rbd_rst_sync.sv
module rbd_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/rbd_bus_mux.sv
module rbd_bus_mux #(
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned NUM_SRC = 7,
  parameter int unsigned SEL_W   = 3
) (
  input  logic [NUM_SRC*DATA_W-1:0] src_flat,
  input  logic [SEL_W-1:0]          sel,
  output logic [DATA_W-1:0]         bus
);
  // One NUM_SRC-to-1 selector per bus line; unused codes give zero.
  for (genvar b = 0; b < DATA_W; b++) begin : g_line
    always_comb begin
      bus[b] = 1'b0;
      for (int s = 0; s < NUM_SRC; s++) begin
        if (sel == SEL_W'(s)) bus[b] = src_flat[s*DATA_W + b];
      end
    end
  end
endmodule

// File: rtl/rbd_load_dec.sv
module rbd_load_dec #(
  parameter int unsigned NUM_DST = 6,
  parameter int unsigned SEL_W   = 3
) (
  input  logic               en,
  input  logic [SEL_W-1:0]   code,
  output logic [NUM_DST-1:0] ld
);
  always_comb begin
    ld = '0;
    for (int i = 0; i < NUM_DST; i++) begin
      if (code == SEL_W'(i)) ld[i] = en;
    end
  end
endmodule

// File: rtl/rbd_word_mem.sv
module rbd_word_mem #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned DEPTH  = 16,
  localparam int unsigned AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [AW-1:0]     addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem_q[addr] <= wdata;
  end

  assign rdata = mem_q[addr];
endmodule

// File: rtl/rbd_datapath.sv
module rbd_datapath #(
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned NUM_GPR   = 4,
  parameter int unsigned MEM_DEPTH = 16,
  localparam int unsigned NUM_SRC  = NUM_GPR + rbd_pkg::EXTRA_SRC,
  localparam int unsigned NUM_DST  = NUM_GPR + rbd_pkg::EXTRA_DST,
  localparam int unsigned SEL_W    = $clog2(NUM_SRC + 1),
  localparam int unsigned GI_W     = $clog2(NUM_GPR),
  localparam int unsigned ADDR_W   = $clog2(MEM_DEPTH)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [DATA_W-1:0]         ext_din,
  input  logic [SEL_W-1:0]          bus_src,
  input  logic [SEL_W-1:0]          bus_dst,
  input  logic                      xfer_en,
  input  logic                      swap_en,
  input  logic [GI_W-1:0]           swap_a,
  input  logic [GI_W-1:0]           swap_b,
  input  logic                      mem_rd,
  input  logic                      mem_wr,
  input  logic [GI_W-1:0]           wr_src,
  output logic [DATA_W-1:0]         bus_o,
  output logic [NUM_GPR*DATA_W-1:0] gpr_o,
  output logic [DATA_W-1:0]         ar_o,
  output logic [DATA_W-1:0]         dr_o
);
  import rbd_pkg::*;

  localparam int unsigned AR_IDX  = NUM_GPR + OFS_AR;
  localparam int unsigned DR_IDX  = NUM_GPR + OFS_DR;
  localparam int unsigned EXT_IDX = NUM_GPR + OFS_EXT;

  logic                      rst_sync_n;
  logic [DATA_W-1:0]         gpr_q   [NUM_GPR];
  logic [DATA_W-1:0]         gpr_nxt [NUM_GPR];
  logic [NUM_GPR-1:0]        gpr_en;
  logic [DATA_W-1:0]         ar_q, ar_nxt, dr_q, dr_nxt;
  logic                      ar_en, dr_en;
  logic [NUM_SRC*DATA_W-1:0] src_flat;
  logic [DATA_W-1:0]         bus;
  logic [NUM_DST-1:0]        ld_vec;
  logic                      rd_take;
  logic [DATA_W-1:0]         mem_rdata;

  rbd_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n));

  // Bus source assembly
  always_comb begin
    for (int g = 0; g < NUM_GPR; g++) src_flat[g*DATA_W +: DATA_W] = gpr_q[g];
    src_flat[AR_IDX*DATA_W  +: DATA_W] = ar_q;
    src_flat[DR_IDX*DATA_W  +: DATA_W] = dr_q;
    src_flat[EXT_IDX*DATA_W +: DATA_W] = ext_din;
  end

  rbd_bus_mux #(.DATA_W(DATA_W), .NUM_SRC(NUM_SRC), .SEL_W(SEL_W)) u_mux (
    .src_flat(src_flat), .sel(bus_src), .bus(bus)
  );

  // A swap suppresses the bus transfer in its cycle.
  rbd_load_dec #(.NUM_DST(NUM_DST), .SEL_W(SEL_W)) u_dec (
    .en(xfer_en & ~swap_en), .code(bus_dst), .ld(ld_vec)
  );

  rbd_word_mem #(.DATA_W(DATA_W), .DEPTH(MEM_DEPTH)) u_mem (
    .clk(clk), .we(mem_wr), .addr(ar_q[ADDR_W-1:0]),
    .wdata(gpr_q[wr_src]), .rdata(mem_rdata)
  );

  // Next-state logic
  always_comb begin
    for (int i = 0; i < NUM_GPR; i++) begin
      gpr_nxt[i] = ld_vec[i] ? bus : gpr_q[i];
      gpr_en[i]  = ld_vec[i];
      if (swap_en && swap_a != swap_b) begin
        if (swap_a == GI_W'(i)) begin
          gpr_nxt[i] = gpr_q[swap_b];
          gpr_en[i]  = 1'b1;
        end else if (swap_b == GI_W'(i)) begin
          gpr_nxt[i] = gpr_q[swap_a];
          gpr_en[i]  = 1'b1;
        end
      end
    end
  end

  assign rd_take = mem_rd & ~mem_wr;
  assign ar_en   = ld_vec[AR_IDX];
  assign ar_nxt  = bus;
  assign dr_en   = rd_take | ld_vec[DR_IDX];
  assign dr_nxt  = rd_take ? mem_rdata : bus;

  // Registers
  for (genvar i = 0; i < NUM_GPR; i++) begin : g_gpr
    always_ff @(posedge clk or negedge rst_sync_n) begin
      if (!rst_sync_n)    gpr_q[i] <= '0;
      else if (gpr_en[i]) gpr_q[i] <= gpr_nxt[i];
    end
    assign gpr_o[i*DATA_W +: DATA_W] = gpr_q[i];
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) ar_q <= '0;
    else if (ar_en)  ar_q <= ar_nxt;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) dr_q <= '0;
    else if (dr_en)  dr_q <= dr_nxt;
  end

  assign bus_o = bus;
  assign ar_o  = ar_q;
  assign dr_o  = dr_q;
endmodule

// File: rtl/rbd_datapath_chk.sv
module rbd_datapath_chk #(
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned NUM_GPR = 4,
  localparam int unsigned NUM_SRC = NUM_GPR + rbd_pkg::EXTRA_SRC,
  localparam int unsigned NUM_DST = NUM_GPR + rbd_pkg::EXTRA_DST,
  localparam int unsigned SEL_W   = $clog2(NUM_SRC + 1),
  localparam int unsigned GI_W    = $clog2(NUM_GPR)
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic [SEL_W-1:0]          bus_dst,
  input logic                      xfer_en,
  input logic                      swap_en,
  input logic [GI_W-1:0]           swap_a,
  input logic [GI_W-1:0]           swap_b,
  input logic                      mem_rd,
  input logic                      mem_wr,
  input logic [DATA_W-1:0]         bus_o,
  input logic [NUM_GPR*DATA_W-1:0] gpr_o,
  input logic [DATA_W-1:0]         ar_o,
  input logic [DATA_W-1:0]         dr_o,
  input logic [NUM_DST-1:0]        ld_vec
);
  logic [DATA_W-1:0] g [NUM_GPR];
  always_comb begin
    for (int i = 0; i < NUM_GPR; i++) g[i] = gpr_o[i*DATA_W +: DATA_W];
  end

  a_r3_gpr_load: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_en && !swap_en && bus_dst <= SEL_W'(NUM_GPR-1))
      |=> g[$past(bus_dst[GI_W-1:0])] == $past(bus_o));

  a_r3_ar_load: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_en && !swap_en && bus_dst == SEL_W'(NUM_GPR)) |=> ar_o == $past(bus_o));

  a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!xfer_en && !swap_en && !mem_rd)
      |=> ($stable(gpr_o) && $stable(ar_o) && $stable(dr_o)));

  a_r5_swap: assert property (@(posedge clk) disable iff (!rst_n)
    swap_en |=> g[$past(swap_a)] == $past(g[swap_b]));

  a_r5_swap_ar_kept: assert property (@(posedge clk) disable iff (!rst_n)
    swap_en |=> $stable(ar_o));

  a_r8_rdwr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd && mem_wr && !(xfer_en && !swap_en && bus_dst == SEL_W'(NUM_GPR+1)))
      |=> $stable(dr_o));

  a_r9_onehot_load: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ld_vec));
endmodule

bind rbd_datapath rbd_datapath_chk #(.DATA_W(DATA_W), .NUM_GPR(NUM_GPR)) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .bus_dst(bus_dst), .xfer_en(xfer_en),
  .swap_en(swap_en), .swap_a(swap_a), .swap_b(swap_b), .mem_rd(mem_rd),
  .mem_wr(mem_wr), .bus_o(bus_o), .gpr_o(gpr_o), .ar_o(ar_o), .dr_o(dr_o),
  .ld_vec(ld_vec)
);

// File: tb/tb_rbd_datapath.sv
module tb_rbd_datapath;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  ext_din;
  logic [2:0]  bus_src, bus_dst;
  logic        xfer_en, swap_en, mem_rd, mem_wr;
  logic [1:0]  swap_a, swap_b, wr_src;
  logic [7:0]  bus_o, ar_o, dr_o;
  logic [31:0] gpr_o;
  int errors = 0;
  int checks = 0;

  always #10 clk = ~clk;

  rbd_datapath dut (
    .clk(clk), .rst_n(rst_n), .ext_din(ext_din), .bus_src(bus_src),
    .bus_dst(bus_dst), .xfer_en(xfer_en), .swap_en(swap_en), .swap_a(swap_a),
    .swap_b(swap_b), .mem_rd(mem_rd), .mem_wr(mem_wr), .wr_src(wr_src),
    .bus_o(bus_o), .gpr_o(gpr_o), .ar_o(ar_o), .dr_o(dr_o)
  );

  // {src, dst, xfer, din, expected bus, expected destination after edge}
  localparam logic [30:0] VEC [0:9] = '{
    {3'd6, 3'd0, 1'b1, 8'h11, 8'h11, 8'h11},
    {3'd6, 3'd1, 1'b1, 8'h22, 8'h22, 8'h22},
    {3'd6, 3'd2, 1'b1, 8'h33, 8'h33, 8'h33},
    {3'd6, 3'd3, 1'b1, 8'h44, 8'h44, 8'h44},
    {3'd0, 3'd4, 1'b1, 8'h00, 8'h11, 8'h11},
    {3'd3, 3'd5, 1'b1, 8'h00, 8'h44, 8'h44},
    {3'd4, 3'd2, 1'b1, 8'h00, 8'h11, 8'h11},
    {3'd5, 3'd0, 1'b1, 8'h00, 8'h44, 8'h44},
    {3'd1, 3'd3, 1'b0, 8'h00, 8'h22, 8'h44},
    {3'd7, 3'd1, 1'b1, 8'hAA, 8'h00, 8'h00}
  };

  function automatic logic [7:0] reg_val(input logic [2:0] code);
    if (code < 3'd4)       return gpr_o[code*8 +: 8];
    else if (code == 3'd4) return ar_o;
    else                   return dr_o;
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    xfer_en = 0; swap_en = 0; mem_rd = 0; mem_wr = 0;
    bus_src = 3'd7; bus_dst = 3'd7; ext_din = 8'h00;
    swap_a = 0; swap_b = 0; wr_src = 0;
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    idle();
  endtask

  task automatic put(input logic [2:0] dst, input logic [7:0] din);
    bus_src = 3'd6; bus_dst = dst; ext_din = din; xfer_en = 1;
    step();
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    idle();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    for (int i = 0; i < 4; i++) chk("R1 reset gpr", gpr_o[i*8 +: 8], 8'h00);
    chk("R1 reset ar", ar_o, 8'h00);
    chk("R1 reset dr", dr_o, 8'h00);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    for (int v = 0; v < 10; v++) begin
      bus_src = VEC[v][30:28]; bus_dst = VEC[v][27:25];
      xfer_en = VEC[v][24];    ext_din = VEC[v][23:16];
      #1;
      chk($sformatf("R2 bus row %0d", v), bus_o, VEC[v][15:8]);
      step();
      chk($sformatf("R3/R4 dest row %0d", v), reg_val(VEC[v][27:25]), VEC[v][7:0]);
      if (v == 0) chk("R9 other reg untouched", gpr_o[15:8], 8'h00);
    end
    // gpr = 44,00,11,44  AR=11  DR=44

    put(3'd1, 8'h5A);
    swap_en = 1; swap_a = 0; swap_b = 1;
    xfer_en = 1; bus_src = 3'd6; ext_din = 8'hFF; bus_dst = 3'd2;
    step();
    chk("R5 swap a", gpr_o[7:0], 8'h5A);
    chk("R5 swap b", gpr_o[15:8], 8'h44);
    chk("R5 bus load suppressed", gpr_o[23:16], 8'h11);
    swap_en = 1; swap_a = 3; swap_b = 3;
    step();
    chk("R5 self swap", gpr_o[31:24], 8'h44);

    put(3'd4, 8'h03);
    mem_wr = 1; wr_src = 0; step();
    put(3'd4, 8'h07);
    mem_wr = 1; wr_src = 1; step();
    chk("R7 ar unchanged by write", ar_o, 8'h07);
    put(3'd4, 8'h03);
    mem_rd = 1; xfer_en = 1; bus_src = 3'd6; ext_din = 8'h99; bus_dst = 3'd5;
    step();
    chk("R6 read beats bus load", dr_o, 8'h5A);
    put(3'd4, 8'h07);
    mem_rd = 1; step();
    chk("R7 second word", dr_o, 8'h44);

    mem_rd = 1; mem_wr = 1; wr_src = 2; step();
    chk("R8 dr holds on rd+wr", dr_o, 8'h44);
    mem_rd = 1; step();
    chk("R8 write took effect", dr_o, 8'h11);

    put(3'd6, 8'h77);
    chk("R3 code6 gpr0", gpr_o[7:0], 8'h5A);
    chk("R3 code6 gpr1", gpr_o[15:8], 8'h44);
    chk("R3 code6 gpr2", gpr_o[23:16], 8'h11);
    chk("R3 code6 gpr3", gpr_o[31:24], 8'h44);
    chk("R3 code6 ar", ar_o, 8'h07);
    chk("R3 code6 dr", dr_o, 8'h11);

    #3 rst_n = 1'b0;
    #1;
    chk("R1 async reset gpr0", gpr_o[7:0], 8'h00);
    chk("R1 async reset ar", ar_o, 8'h00);
    chk("R1 async reset dr", dr_o, 8'h00);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule